// File: doc/BRIEF.md
# Operand Barrel Shifter with Shifter Carry

This combinational block prepares the second operand of a data-processing datapath. It takes a 32-bit value and shifts or rotates it by an amount that comes either from a 5-bit instruction immediate or from the low byte of a register. It also returns the carry the logical instructions use as their C flag. Five operations are available: logical left, logical right, arithmetic right, rotate right, and a single-bit rotate that passes through the carry flag.

The immediate encoding reuses its zero amounts. An immediate zero right shift means a shift by 32, and an immediate zero rotate selects the carry-through rotate. A register amount of zero leaves the value and the carry untouched. Decoding of the instruction fields and the rotated-immediate operand form are handled outside this block.

Top module: `bshift_top`

## Requirements
- R1: With `amt_is_reg_i`=1 and `amount_i`=0, `result_o` equals `value_i` and `carry_o` equals `carry_i`, whatever the kind.
- R2: With `amt_is_reg_i`=0 only `amount_i[4:0]` is used and bits 7:5 are ignored. An immediate left shift of 0 passes `value_i` through with `carry_o`=`carry_i`.
- R3: Left shift (kind 0) by n in 1..32 gives `value_i<<n`, with carry equal to bit 32-n of the input. For n above 32 the result is 0 and the carry is 0.
- R4: Logical right shift (kind 1) by n in 1..32 gives `value_i>>n` with zero fill, with carry equal to input bit n-1. For n above 32 the result is 0 and the carry is 0. An immediate amount of 0 means 32.
- R5: Arithmetic right shift (kind 2) fills with the sign bit, with carry equal to input bit n-1. For n of 32 or more every result bit and the carry equal the sign bit. An immediate amount of 0 means 32.
- R6: Rotate right (kind 3) uses the amount modulo 32, and the carry equals result bit 31. A nonzero multiple of 32 returns the value unchanged with carry equal to input bit 31.
- R7: An immediate rotate of 0 is the carry-through rotate. The result is `{carry_i, value_i[31:1]}` and the carry is `value_i[0]`.
- R8: `kind_i` encodes 0 as left shift, 1 as logical right, 2 as arithmetic right and 3 as rotate right. `amt_is_reg_i`=1 selects the full 8-bit register amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value_i | input | 32 | Operand to shift |
| kind_i | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| amount_i | input | 8 | Shift amount: register byte or immediate in bits 4:0 |
| amt_is_reg_i | input | 1 | 1 = register amount, 0 = immediate |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The hardest situations to reach are the boundaries where the same amount means different things depending on its source. A zero can mean no shift, a shift by 32, or the carry-through rotate. Register amounts of exactly 32, just past 32, and multiples of 32 for rotate each follow their own rule. The stimulus pairs immediate and register forms with the same raw amount byte, and it sweeps register amounts 0 to 63 for every kind on patterns with marked edge bits. This puts the last bit shifted out at the top, at the bottom and past the end of the word.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  typedef enum logic [1:0] {
    KIND_LSL = 2'd0,
    KIND_LSR = 2'd1,
    KIND_ASR = 2'd2,
    KIND_ROR = 2'd3
  } shift_kind_e;

  typedef enum logic [2:0] {
    OP_PASS,
    OP_LSL,
    OP_LSR,
    OP_ASR,
    OP_ROR,
    OP_RRX
  } shift_op_e;
endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  shift_kind_e      kind_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic             amt_is_reg_i,
  output shift_op_e        op_o,
  output logic [AMT_W-1:0] count_o
);
  localparam int IMM_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  shift_op_e            kind_op;
  logic [IMM_W-1:0]     imm_amt;

  always_comb begin
    unique case (kind_i)
      KIND_LSL: kind_op = OP_LSL;
      KIND_LSR: kind_op = OP_LSR;
      KIND_ASR: kind_op = OP_ASR;
      default:  kind_op = OP_ROR;
    endcase
  end

  assign imm_amt = amount_i[IMM_W-1:0];

  always_comb begin
    op_o    = kind_op;
    count_o = amount_i;
    if (amt_is_reg_i) begin
      if (amount_i == '0) op_o = OP_PASS;
    end else begin
      count_o = AMT_W'(imm_amt);
      if (imm_amt == '0) begin
        // zero immediate is re-purposed per kind
        unique case (kind_i)
          KIND_LSL: op_o = OP_PASS;
          KIND_LSR, KIND_ASR: count_o = FULL;
          default: op_o = OP_RRX;
        endcase
      end
    end
  end

  // R2
  always_comb begin
    if (!amt_is_reg_i && op_o != OP_PASS && op_o != OP_RRX)
      imm_range_chk: assert (count_o != '0 && count_o <= FULL);
  end
endmodule

// File: rtl/bshift_linear.sv
module bshift_linear
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] value_i,
  input  shift_op_e         op_i,
  input  logic [AMT_W-1:0]  count_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  logic [DATA_W:0] left_w, right_w, arith_w;

  // extra bit catches the last bit shifted out
  assign left_w  = {1'b0, value_i} << count_i;
  assign right_w = {value_i, 1'b0} >> count_i;
  assign arith_w = $signed({value_i, 1'b0}) >>> count_i;

  always_comb begin
    unique case (op_i)
      OP_LSL: begin
        result_o = left_w[DATA_W-1:0];
        carry_o  = left_w[DATA_W];
      end
      OP_LSR: begin
        result_o = right_w[DATA_W:1];
        carry_o  = right_w[0];
      end
      default: begin
        result_o = arith_w[DATA_W:1];
        carry_o  = arith_w[0];
      end
    endcase
  end

  // R5
  always_comb begin
    if (op_i == OP_ASR && count_i >= FULL)
      asr_fill_chk: assert (result_o == {DATA_W{value_i[DATA_W-1]}} && carry_o == value_i[DATA_W-1]);
  end

  // R3
  always_comb begin
    if (op_i == OP_LSL && count_i > FULL)
      lsl_clear_chk: assert (result_o == '0 && !carry_o);
  end

  // R4
  always_comb begin
    if (op_i == OP_LSR && count_i == FULL)
      lsr_full_chk: assert (result_o == '0 && carry_o == value_i[DATA_W-1]);
  end
endmodule

// File: rtl/bshift_rotate.sv
module bshift_rotate #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [AMT_W-1:0]  count_i,
  input  logic              through_carry_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  localparam int RW = $clog2(DATA_W);

  logic [RW-1:0]     rot;
  logic [DATA_W-1:0] rot_val;

  assign rot = count_i[RW-1:0];  // DATA_W is a power of two

  always_comb begin
    if (rot == '0) rot_val = value_i;
    else           rot_val = (value_i >> rot) | (value_i << (DATA_W - int'(rot)));
  end

  always_comb begin
    if (through_carry_i) begin
      result_o = {carry_i, value_i[DATA_W-1:1]};
      carry_o  = value_i[0];
    end else begin
      result_o = rot_val;
      carry_o  = rot_val[DATA_W-1];
    end
  end

  // R6
  always_comb begin
    if (!through_carry_i)
      ror_ones_chk: assert ($countones(result_o) == $countones(value_i));
  end

  // R7
  always_comb begin
    if (through_carry_i)
      rrx_ones_chk: assert ($countones({result_o, carry_o}) == $countones({value_i, carry_i}));
  end
endmodule

// File: rtl/bshift_top.sv
module bshift_top
  import bshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [1:0]        kind_i,
  input  logic [AMT_W-1:0]  amount_i,
  input  logic              amt_is_reg_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  shift_op_e         op;
  logic [AMT_W-1:0]  count;
  logic [DATA_W-1:0] lin_res, rot_res;
  logic              lin_c, rot_c;

  bshift_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_decode (
    .kind_i      (shift_kind_e'(kind_i)),
    .amount_i    (amount_i),
    .amt_is_reg_i(amt_is_reg_i),
    .op_o        (op),
    .count_o     (count)
  );

  bshift_linear #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_linear (
    .value_i (value_i),
    .op_i    (op),
    .count_i (count),
    .result_o(lin_res),
    .carry_o (lin_c)
  );

  bshift_rotate #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rotate (
    .value_i        (value_i),
    .count_i        (count),
    .through_carry_i(op == OP_RRX),
    .carry_i        (carry_i),
    .result_o       (rot_res),
    .carry_o        (rot_c)
  );

  always_comb begin
    unique case (op)
      OP_PASS: begin
        result_o = value_i;
        carry_o  = carry_i;
      end
      OP_ROR, OP_RRX: begin
        result_o = rot_res;
        carry_o  = rot_c;
      end
      default: begin
        result_o = lin_res;
        carry_o  = lin_c;
      end
    endcase
  end

  // R1
  always_comb begin
    if (amt_is_reg_i && amount_i == '0)
      reg_zero_chk: assert (result_o == value_i && carry_o == carry_i);
  end
endmodule

// File: tb/bshift_top_tb.sv
module bshift_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] value;
  logic [1:0]  kind;
  logic [7:0]  amount;
  logic        is_reg;
  logic        cin;
  logic [31:0] res;
  logic        cout;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bshift_top u_dut (
    .value_i     (value),
    .kind_i      (kind),
    .amount_i    (amount),
    .amt_is_reg_i(is_reg),
    .carry_i     (cin),
    .result_o    (res),
    .carry_o     (cout)
  );

  // {value, kind, amount, is_reg, cin, exp_res, exp_c}
  localparam int NV = 18;
  localparam logic [76:0] VEC [NV] = '{
    {32'h8000_0001, 2'd0, 8'd0,   1'b1, 1'b1, 32'h8000_0001, 1'b1}, // R1
    {32'h8000_0001, 2'd0, 8'd1,   1'b0, 1'b0, 32'h0000_0002, 1'b1}, // R3
    {32'h0000_0003, 2'd0, 8'd32,  1'b1, 1'b0, 32'h0000_0000, 1'b1}, // R3
    {32'hFFFF_FFFF, 2'd0, 8'd33,  1'b1, 1'b1, 32'h0000_0000, 1'b0}, // R3
    {32'h8000_0000, 2'd1, 8'd0,   1'b0, 1'b0, 32'h0000_0000, 1'b1}, // R4
    {32'h0000_00F8, 2'd1, 8'd4,   1'b0, 1'b0, 32'h0000_000F, 1'b1}, // R4
    {32'h8000_0010, 2'd2, 8'd4,   1'b0, 1'b1, 32'hF800_0001, 1'b0}, // R5
    {32'h8000_0000, 2'd2, 8'd200, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R5
    {32'h7FFF_FFFF, 2'd2, 8'd0,   1'b0, 1'b1, 32'h0000_0000, 1'b0}, // R5
    {32'h0000_0001, 2'd3, 8'd1,   1'b0, 1'b0, 32'h8000_0000, 1'b1}, // R6
    {32'h1234_5678, 2'd3, 8'd64,  1'b1, 1'b1, 32'h1234_5678, 1'b0}, // R6
    {32'h0000_00F1, 2'd3, 8'd36,  1'b1, 1'b1, 32'h1000_000F, 1'b0}, // R6
    {32'h0000_0003, 2'd3, 8'd0,   1'b0, 1'b1, 32'h8000_0001, 1'b1}, // R7
    {32'h0000_0002, 2'd3, 8'd0,   1'b0, 1'b0, 32'h0000_0001, 1'b0}, // R7
    {32'h0000_0001, 2'd0, 8'h21,  1'b0, 1'b0, 32'h0000_0002, 1'b0}, // R2
    {32'hABCD_0000, 2'd0, 8'h20,  1'b0, 1'b1, 32'hABCD_0000, 1'b1}, // R2
    {32'h0000_00FF, 2'd0, 8'hE0,  1'b1, 1'b1, 32'h0000_0000, 1'b0}, // R8
    {32'h0000_0002, 2'd3, 8'h41,  1'b1, 1'b1, 32'h0000_0001, 1'b0}  // R8
  };
  localparam int TAG [NV] = '{1, 3, 3, 3, 4, 4, 5, 5, 5, 6, 6, 6, 7, 7, 2, 2, 8, 8};

  // reference model: one bit per step, straight from the requirements
  function automatic logic [32:0] ref_shift(logic [31:0] v, logic [1:0] k,
                                             logic [7:0] a, logic r, logic c);
    int n;
    logic [31:0] x = v;
    logic cc = c;
    if (r) n = int'(a);
    else begin
      n = int'(a[4:0]);
      if (n == 0) begin
        if (k == 2'd1 || k == 2'd2) n = 32;
        if (k == 2'd3) return {c, v[31:1], v[0]};
      end
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin cc = x[31]; x = {x[30:0], 1'b0}; end
        2'd1: begin cc = x[0];  x = {1'b0, x[31:1]}; end
        2'd2: begin cc = x[0];  x = {x[31], x[31:1]}; end
        default: begin cc = x[0]; x = {x[0], x[31:1]}; end
      endcase
    end
    return {x, cc};
  endfunction

  task automatic apply(logic [31:0] v, logic [1:0] k, logic [7:0] a, logic r, logic c);
    @(negedge clk);
    value = v; kind = k; amount = a; is_reg = r; cin = c;
    @(posedge clk);
    #2;
  endtask

  task automatic check(int tag, logic [31:0] er, logic ec);
    total++;
    if (res !== er || cout !== ec) begin
      bad++;
      $display("FAIL R%0d: v=%h k=%0d a=%0d reg=%0b cin=%0b got %h/%0b exp %h/%0b",
               tag, value, kind, amount, is_reg, cin, res, cout, er, ec);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [32:0] exp;
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hC3A5_5A3C; pats[3] = 32'h0000_0000;
    value = '0; kind = '0; amount = '0; is_reg = 1'b0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // idle inputs: immediate LSL 0 of zero passes through (R2)
    apply(32'h0, 2'd0, 8'd0, 1'b0, 1'b0);
    check(2, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][76:45], VEC[i][44:43], VEC[i][42:35], VEC[i][34], VEC[i][33]);
      check(TAG[i], VEC[i][32:1], VEC[i][0]);
    end

    // R1 register zero for every kind
    for (int k = 0; k < 4; k++) begin
      apply(32'h5A5A_A5A5, 2'(k), 8'd0, 1'b1, 1'b1);
      check(1, 32'h5A5A_A5A5, 1'b1);
    end

    // R3 R4 R5 R6 R7 sweep: register and immediate amounts across the 32 boundary
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 4; p++)
        for (int r = 0; r < 2; r++)
          for (int c = 0; c < 2; c++)
            for (int a = 0; a < 64; a++) begin
              exp = ref_shift(pats[p], 2'(k), 8'(a), r[0], c[0]);
              apply(pats[p], 2'(k), 8'(a), r[0], c[0]);
              check(3 + k, exp[32:1], exp[0]);
            end

    // R8 large register amounts
    for (int k = 0; k < 4; k++) begin
      exp = ref_shift(32'h9000_0001, 2'(k), 8'd255, 1'b1, 1'b0);
      apply(32'h9000_0001, 2'(k), 8'd255, 1'b1, 1'b0);
      check(8, exp[32:1], exp[0]);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule